// File: doc/BRIEF.md
# Hashed Exact-Match Lookup Table

This block is an exact-match search engine for wide keys such as flow identifiers or link-layer addresses. A search key is folded by XOR into a short slot number, and that number selects an entry in an on-chip table. Each entry holds a valid flag, the full original key and a result word. Comparing the full key tells apart different keys that fold to the same slot.

A request is accepted on a valid/ready handshake. The first cycle registers the folded slot number. Each following cycle probes one candidate slot and compares keys. The candidates are the home slot and then the next slots in order, wrapping around the table, with at most four probes per request. A response comes back as a one-cycle pulse that carries a hit flag, a result and the probe count. Latency therefore depends on how many colliding keys sit ahead of the one being searched.

The same port carries three kinds of request: lookup, insert and delete. The default table has sixteen slots, about twice the number of keys it is meant to hold, so that colliding keys have room.

Top module: `hashed_match_table`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and every slot is empty, so any lookup misses on its first probe.
- R2: The home slot of a key is the XOR of all its IDX_W-bit groups (bits [3:0] ^ [7:4] ^ ... for the default widths); a key stored in an empty home slot is found with a probe count of 1.
- R3: A lookup (req_op 2'b00) of a stored key returns rsp_hit=1 and the result stored with that key.
- R4: Probe k (k = 1..4) examines slot (home + k - 1) modulo the table depth, and rsp_probes reports the number of probes made, always between 1 and 4.
- R5: A lookup or delete that meets an empty slot, or examines four occupied slots without a key match, ends with rsp_hit=0 and rsp_result=0.
- R6: An insert (req_op 2'b01) writes the key and result into the first candidate slot that is empty or already holds the same key (updating its result), and returns rsp_hit=1; if all four candidates hold other keys it returns rsp_hit=0 and changes nothing.
- R7: A delete (req_op 2'b10) empties the slot holding the matching key and returns rsp_hit=1 with that key's former result; a delete of an absent key returns rsp_hit=0 and changes nothing.
- R8: req_ready is 1 only while idle; rsp_valid is a single-cycle pulse that rises on the p-th rising edge after the accepting edge, where p is the probe count.
- R9: req_op 2'b11 behaves as a lookup, and a lookup never changes the table contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_op | input | 2 | 00 lookup, 01 insert, 10 delete, 11 lookup |
| req_key | input | KEY_W (32) | Search key |
| req_result | input | RES_W (8) | Result word to store on insert |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | Key found, insert done or delete done |
| rsp_result | output | RES_W (8) | Stored result for lookup or delete hits, else 0 |
| rsp_probes | output | $clog2(MAX_PROBE+1) (3) | Number of slots probed |

## Verification
The assertions assume that every request is accepted only while req_ready is high and that req_op may take any of its four values, including the spare code. They also assume that the table state changes only through requests the engine itself completes. The stimulus raises req_valid for exactly one cycle while the engine is idle. It then waits for the response pulse before it issues anything new, so no request is in flight while a response is pending. Keys are built to fold onto a few neighbouring home slots that straddle the wrap point. This forces long probe chains, full candidate windows and holes left by deletes.

// File: rtl/hxl_pkg.sv
package hxl_pkg;

  typedef enum logic [1:0] {
    OP_LOOKUP = 2'b00,
    OP_INSERT = 2'b01,
    OP_DELETE = 2'b10,
    OP_SPARE  = 2'b11
  } hxl_op_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_PROBE = 1'b1
  } hxl_state_e;

endpackage

// File: rtl/hxl_fold_hash.sv
module hxl_fold_hash #(
  parameter int KEY_W = 32,
  parameter int IDX_W = 4
) (
  input  logic [KEY_W-1:0] key,
  output logic [IDX_W-1:0] idx
);
  localparam int FOLDS = (KEY_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = FOLDS * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] part [FOLDS];

  assign padded = PAD_W'(key);

  for (genvar g = 0; g < FOLDS; g++) begin : g_part
    assign part[g] = padded[g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < FOLDS; i++) begin
      idx = idx ^ part[i];
    end
  end

endmodule

// File: rtl/hxl_slot_store.sv
module hxl_slot_store #(
  parameter int KEY_W = 32,
  parameter int RES_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [KEY_W-1:0] rd_key,
  output logic [RES_W-1:0] rd_res,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [RES_W-1:0] wr_res
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] vld_q;
  logic [KEY_W-1:0] key_q [DEPTH];
  logic [RES_W-1:0] res_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else if (slot_we) begin
        vld_q[g] <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (slot_we) begin
        key_q[g] <= wr_key;
        res_q[g] <= wr_res;
      end
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_key   = key_q[rd_idx];
  assign rd_res   = res_q[rd_idx];

endmodule

// File: rtl/hxl_probe_ctrl.sv
module hxl_probe_ctrl
  import hxl_pkg::*;
#(
  parameter int KEY_W     = 32,
  parameter int RES_W     = 8,
  parameter int IDX_W     = 4,
  parameter int MAX_PROBE = 4,
  localparam int CNT_W    = $clog2(MAX_PROBE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [KEY_W-1:0] req_key,
  input  logic [RES_W-1:0] req_result,
  input  logic [IDX_W-1:0] hash_idx,
  output logic [IDX_W-1:0] rd_idx,
  input  logic             rd_valid,
  input  logic [KEY_W-1:0] rd_key,
  input  logic [RES_W-1:0] rd_res,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             wr_valid,
  output logic [KEY_W-1:0] wr_key,
  output logic [RES_W-1:0] wr_res,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [RES_W-1:0] rsp_result,
  output logic [CNT_W-1:0] rsp_probes
);
  hxl_state_e       state_q, state_d;
  hxl_op_e          op_q;
  logic [KEY_W-1:0] key_q;
  logic [RES_W-1:0] res_q;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cap_en;

  logic             rsp_valid_q, rsp_valid_d;
  logic             rsp_hit_q, rsp_hit_d;
  logic [RES_W-1:0] rsp_res_q, rsp_res_d;
  logic [CNT_W-1:0] rsp_probes_q, rsp_probes_d;

  logic             slot_match;
  logic             last_probe;
  logic             fin;
  logic             fin_hit;
  logic [RES_W-1:0] fin_res;

  assign req_ready  = (state_q == ST_IDLE);
  assign rd_idx     = idx_q;
  assign wr_idx     = idx_q;
  assign wr_key     = key_q;
  assign wr_res     = res_q;
  assign slot_match = rd_valid && (rd_key == key_q);
  assign last_probe = (cnt_q == CNT_W'(MAX_PROBE));

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    cap_en   = 1'b0;
    wr_en    = 1'b0;
    wr_valid = 1'b0;
    fin      = 1'b0;
    fin_hit  = 1'b0;
    fin_res  = '0;

    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          idx_d   = hash_idx;
          cnt_d   = CNT_W'(1);
          state_d = ST_PROBE;
        end
      end
      ST_PROBE: begin
        case (op_q)
          OP_INSERT: begin
            if (!rd_valid || slot_match) begin
              wr_en    = 1'b1;
              wr_valid = 1'b1;
              fin      = 1'b1;
              fin_hit  = 1'b1;
            end else if (last_probe) begin
              fin = 1'b1;
            end
          end
          OP_DELETE: begin
            if (slot_match) begin
              wr_en    = 1'b1;
              wr_valid = 1'b0;
              fin      = 1'b1;
              fin_hit  = 1'b1;
              fin_res  = rd_res;
            end else if (!rd_valid || last_probe) begin
              fin = 1'b1;
            end
          end
          default: begin
            if (slot_match) begin
              fin     = 1'b1;
              fin_hit = 1'b1;
              fin_res = rd_res;
            end else if (!rd_valid || last_probe) begin
              fin = 1'b1;
            end
          end
        endcase
        if (fin) begin
          state_d = ST_IDLE;
        end else begin
          idx_d = idx_q + IDX_W'(1);
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // response next values
  always_comb begin
    rsp_valid_d  = fin;
    rsp_hit_d    = rsp_hit_q;
    rsp_res_d    = rsp_res_q;
    rsp_probes_d = rsp_probes_q;
    if (fin) begin
      rsp_hit_d    = fin_hit;
      rsp_res_d    = fin_res;
      rsp_probes_d = cnt_q;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      rsp_valid_q  <= 1'b0;
      rsp_hit_q    <= 1'b0;
      rsp_res_q    <= '0;
      rsp_probes_q <= '0;
    end else begin
      state_q      <= state_d;
      rsp_valid_q  <= rsp_valid_d;
      rsp_hit_q    <= rsp_hit_d;
      rsp_res_q    <= rsp_res_d;
      rsp_probes_q <= rsp_probes_d;
    end
  end

  // datapath registers, no reset
  always_ff @(posedge clk) begin
    if (cap_en) begin
      op_q  <= hxl_op_e'(req_op);
      key_q <= req_key;
      res_q <= req_result;
    end
    idx_q <= idx_d;
    cnt_q <= cnt_d;
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_hit    = rsp_hit_q;
  assign rsp_result = rsp_res_q;
  assign rsp_probes = rsp_probes_q;

  assert_probe_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |-> (rsp_probes_q >= CNT_W'(1) && rsp_probes_q <= CNT_W'(MAX_PROBE)));

  assert_miss_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_hit_q) |-> (rsp_res_q == '0));

  assert_insert_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid) |-> (!rd_valid || rd_key == key_q));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q |=> !rsp_valid_q);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !rsp_valid_q));

  assert_lookup_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (op_q == OP_INSERT || op_q == OP_DELETE));

endmodule

// File: rtl/hashed_match_table.sv
module hashed_match_table #(
  parameter int KEY_W     = 32,
  parameter int RES_W     = 8,
  parameter int IDX_W     = 4,
  parameter int MAX_PROBE = 4,
  localparam int CNT_W    = $clog2(MAX_PROBE + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [KEY_W-1:0] req_key,
  input  logic [RES_W-1:0] req_result,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [RES_W-1:0] rsp_result,
  output logic [CNT_W-1:0] rsp_probes
);
  logic [IDX_W-1:0] hash_idx;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_valid;
  logic [KEY_W-1:0] rd_key;
  logic [RES_W-1:0] rd_res;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_valid;
  logic [KEY_W-1:0] wr_key;
  logic [RES_W-1:0] wr_res;

  hxl_fold_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash (
    .key (req_key),
    .idx (hash_idx)
  );

  hxl_slot_store #(.KEY_W(KEY_W), .RES_W(RES_W), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_key   (rd_key),
    .rd_res   (rd_res),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_valid (wr_valid),
    .wr_key   (wr_key),
    .wr_res   (wr_res)
  );

  hxl_probe_ctrl #(
    .KEY_W(KEY_W), .RES_W(RES_W), .IDX_W(IDX_W), .MAX_PROBE(MAX_PROBE)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_key    (req_key),
    .req_result (req_result),
    .hash_idx   (hash_idx),
    .rd_idx     (rd_idx),
    .rd_valid   (rd_valid),
    .rd_key     (rd_key),
    .rd_res     (rd_res),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_valid   (wr_valid),
    .wr_key     (wr_key),
    .wr_res     (wr_res),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_result (rsp_result),
    .rsp_probes (rsp_probes)
  );

endmodule

// File: tb/hashed_match_table_bench.sv
module hashed_match_table_bench;
  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_op;
  logic [31:0] req_key;
  logic [7:0]  req_result;
  logic        rsp_valid;
  logic        rsp_hit;
  logic [7:0]  rsp_result;
  logic [2:0]  rsp_probes;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  // reference table
  logic        mv [16];
  logic [31:0] mk [16];
  logic [7:0]  mr [16];

  hashed_match_table u_hashed_match_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_op     (req_op),
    .req_key    (req_key),
    .req_result (req_result),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_result (rsp_result),
    .rsp_probes (rsp_probes)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_checks++;
      n_fails++;
      $display("FAIL R8 watchdog: act %0d cycles exp fewer", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: act %0h exp %0h", tag, act, exp);
    end
  endtask

  function automatic int fold(input logic [31:0] k);
    int h = 0;
    for (int i = 0; i < 8; i++) h = h ^ ((k >> (4 * i)) % 16);
    return h;
  endfunction

  function automatic logic [31:0] mkkey(input int unsigned s, input int h);
    logic [31:0] k;
    k = (s * 32'h9E37_79B1) << 4;
    k[3:0] = 4'(fold(k) ^ h);
    return k;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [31:0] key,
                        input logic [7:0] res, input string tag);
    int h, s, ep, w;
    bit ehit, done;
    logic [7:0] eres;
    h = fold(key); ep = 0; ehit = 0; eres = 0; done = 0;
    for (int p = 1; p <= 4 && !done; p++) begin
      bit m;
      s = (h + p - 1) % 16;
      ep = p;
      m = mv[s] && (mk[s] == key);
      if (op == 2'b01) begin
        if (!mv[s] || m) begin
          mv[s] = 1; mk[s] = key; mr[s] = res; ehit = 1; done = 1;
        end
      end else if (op == 2'b10) begin
        if (m) begin
          mv[s] = 0; ehit = 1; eres = mr[s]; done = 1;
        end else if (!mv[s]) done = 1;
      end else begin
        if (m) begin
          ehit = 1; eres = mr[s]; done = 1;
        end else if (!mv[s]) done = 1;
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_key = key; req_result = res;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8 busy", int'(req_ready), 0);
    w = 0;
    while (!rsp_valid && w < 12) begin
      @(negedge clk);
      w++;
    end
    check(w == ep, "R8 latency", w, ep);
    check(int'(rsp_probes) == ep, "R4 probes", int'(rsp_probes), ep);
    check(rsp_hit == ehit, {tag, " hit"}, int'(rsp_hit), int'(ehit));
    check(rsp_result == eres, {tag, " result"}, int'(rsp_result), int'(eres));
  endtask

  initial begin
    logic [31:0] a [5];
    logic [31:0] pool [20];
    logic [31:0] kb, lfsr;
    for (int i = 0; i < 16; i++) mv[i] = 0;
    req_valid = 0; req_op = 0; req_key = 0; req_result = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1 ready in reset", int'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 no rsp in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);

    for (int i = 0; i < 5; i++) a[i] = mkkey(i + 1, 14);
    run_op(2'b00, a[0], 8'h00, "R1 empty lookup");
    run_op(2'b01, a[0], 8'h11, "R2 home insert");
    run_op(2'b01, a[1], 8'h22, "R6 second slot");
    run_op(2'b01, a[2], 8'h33, "R4 wrap insert");
    run_op(2'b01, a[3], 8'h44, "R6 fourth slot");
    run_op(2'b01, a[4], 8'h55, "R6 full window");
    run_op(2'b00, a[4], 8'h00, "R5 four probe miss");
    run_op(2'b00, a[0], 8'h00, "R2 home lookup");
    run_op(2'b00, a[2], 8'h00, "R3 wrapped hit");
    run_op(2'b01, a[1], 8'h99, "R6 update");
    run_op(2'b00, a[1], 8'h00, "R3 updated");
    kb = mkkey(9, 0);
    run_op(2'b01, kb, 8'h66, "R4 displaced insert");
    run_op(2'b00, kb, 8'h00, "R3 displaced hit");
    run_op(2'b10, a[1], 8'h00, "R7 delete");
    run_op(2'b00, a[2], 8'h00, "R5 hole miss");
    run_op(2'b10, a[1], 8'h00, "R7 absent delete");
    run_op(2'b01, a[4], 8'h77, "R6 refill hole");
    run_op(2'b11, a[0], 8'h00, "R9 spare code lookup");
    run_op(2'b11, mkkey(40, 3), 8'h00, "R9 spare code miss");

    for (int i = 0; i < 20; i++) pool[i] = mkkey(200 + i, (14 + i % 5) % 16);
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 1500; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[1:0])
        2'b01: run_op(2'b01, pool[lfsr[12:8] % 20], lfsr[23:16], "R6 sweep");
        2'b10: run_op(2'b10, pool[lfsr[12:8] % 20], 8'h00, "R7 sweep");
        2'b11: run_op(2'b11, pool[lfsr[12:8] % 20], 8'h00, "R9 sweep");
        default: run_op(2'b00, pool[lfsr[12:8] % 20], 8'h00, "R3 sweep");
      endcase
    end
    summary();
  end

endmodule